// File: doc/BRIEF.md
# Multi-Warp Issue Scheduler with Divergence Stack

This block decides, every clock cycle, which of several resident warps sends its next instruction down the pipeline. Each warp is a group of 32 lanes that run one shared instruction stream in lockstep. A warp can issue when its instruction source reports it ready and it is not waiting on memory. Among the warps that can issue, a rotating pointer chooses the first one after the warp that issued last. When no warp can issue, the block emits a bubble and raises an idle flag. A per-warp stall input parks a warp as soon as it sends a memory request. A completion input, tagged with a warp number, releases that warp again.

Each warp keeps its own program counter, a 32-bit active-lane mask and a small reconvergence stack. The branch outcome for the instruction issued in a cycle arrives in that same cycle as a per-lane taken mask, a target and a reconvergence address. A branch on which the active lanes disagree splits the warp. The taken lanes run first, and the other lanes stay masked off. When execution reaches the reconvergence address, the held-back lanes run from the instruction after the branch. When those lanes reach the same address, the stack entry is dropped and the full mask comes back. Decode, the execution lanes and the memory system are outside this block.

Top module: `warp_sched_top`

## Requirements
- R1: After reset, warp w has program counter w*PC_STRIDE and an all-ones 32-bit mask, and no warp is stalled. The rotation pointer points at the last warp, so warp 0 is the first to be chosen.
- R2: A warp is eligible when its `warp_ready_i` bit is 1 and its stall bit is clear. The issue outputs reflect eligibility in the same cycle, and a warp that is not ready is never chosen.
- R3: Among the eligible warps, the one chosen is the first found in ascending index order, wrapping around, starting just after the warp that issued last.
- R4: When no warp is eligible, `issue_valid_o` is 0 and `idle_o` is 1. Otherwise `issue_valid_o` is 1 and `idle_o` is 0.
- R5: A 1 on `stall_set_i[w]` stalls warp w from the next cycle onward. A stalled warp is skipped by the rotation.
- R6: `cpl_valid_i` with warp number `cpl_warp_i` clears that warp's stall bit from the next cycle. If the same warp receives a stall request in the same cycle, the stall wins.
- R7: An issue with no branch advances the program counter of the issuing warp by 1 and leaves its mask unchanged. Warps that do not issue keep their program counter and mask.
- R8: A branch is uniform when all active lanes are taken or none are. A uniform branch pushes nothing and leaves the mask as it is. The next program counter is the target if all active lanes are taken, and the branch address plus 1 otherwise.
- R9: A divergent branch pushes one stack entry and continues at the target. The new mask holds only the active lanes that were taken, and the other lanes issue with their mask bit at 0.
- R10: When the next program counter equals the reconvergence address of the top entry and the held-back lanes have not yet run, the warp continues at the branch address plus 1. Its mask is the lanes that were active but not taken.
- R11: When the next program counter equals the reconvergence address of the top entry and both paths have run, the entry is popped. The mask saved at the branch is restored, and the warp continues at the reconvergence address. Nesting is limited to STACK_DEPTH entries.
- R12: Bits of the taken mask for lanes that are inactive are ignored when a branch is classified as uniform or divergent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| warp_ready_i | input | NUM_WARPS | Per-warp instruction-available flag |
| stall_set_i | input | NUM_WARPS | Per-warp memory stall request |
| cpl_valid_i | input | 1 | Memory completion strobe |
| cpl_warp_i | input | log2(NUM_WARPS) | Warp number of the completion |
| br_valid_i | input | 1 | The instruction issued this cycle is a branch |
| br_taken_i | input | 32 | Per-lane taken outcome of that branch |
| br_target_i | input | PC_W | Branch target address |
| br_reconv_i | input | PC_W | Reconvergence address of the branch |
| issue_valid_o | output | 1 | An instruction is issued this cycle |
| idle_o | output | 1 | Bubble: no warp eligible |
| issue_warp_o | output | log2(NUM_WARPS) | Issuing warp number |
| issue_pc_o | output | PC_W | Program counter of the issued instruction |
| issue_mask_o | output | 32 | Active-lane mask of the issued instruction |

## Verification
The issue outputs are combinational from registered state. The choice of warp therefore shows in the cycle in which the ready inputs are applied. A stall request, a completion, or a branch outcome registers at the next clock edge, so its effect shows in the issue outputs of the following cycle. The bench drives each cycle's inputs at the falling edge. In the same step it queues the expected issue for that cycle. The monitor compares the expected issue with the outputs shortly after that edge, well before the rising edge. Every stall, completion and branch is therefore judged by the outputs of the next queued cycle.

// File: rtl/warp_sched_pkg.sv
`timescale 1ns/1ps
package warp_sched_pkg;

    localparam int unsigned LANES = 32;

    typedef logic [LANES-1:0] lane_mask_t;

    typedef enum logic [1:0] {
        BK_PLAIN,
        BK_ALL,
        BK_NONE,
        BK_SPLIT
    } br_kind_e;

    // Classify a branch against the lanes that are currently active.
    function automatic br_kind_e classify_branch(
        input logic       is_branch,
        input lane_mask_t taken,
        input lane_mask_t active
    );
        lane_mask_t live_taken;
        live_taken = taken & active;
        if (!is_branch)                classify_branch = BK_PLAIN;
        else if (live_taken == active) classify_branch = BK_ALL;
        else if (live_taken == '0)     classify_branch = BK_NONE;
        else                           classify_branch = BK_SPLIT;
    endfunction

endpackage

// File: rtl/stall_tracker.sv
`timescale 1ns/1ps
module stall_tracker #(
    parameter int unsigned NUM_WARPS = 4,
    localparam int unsigned WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WARPS-1:0] stall_set_i,
    input  logic                 cpl_valid_i,
    input  logic [WID_W-1:0]     cpl_warp_i,
    output logic [NUM_WARPS-1:0] stall_o
);

    typedef struct packed {
        logic [NUM_WARPS-1:0] parked;
    } stall_state_t;

    stall_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (cpl_valid_i && (32'(cpl_warp_i) < NUM_WARPS)) begin
            state_d.parked[cpl_warp_i] = 1'b0;
        end
        state_d.parked = state_d.parked | stall_set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign stall_o = state_q.parked;

    // R6
    cpl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid_i && (32'(cpl_warp_i) < NUM_WARPS) && !stall_set_i[cpl_warp_i])
        |=> !stall_o[$past(cpl_warp_i)]);

    // R5
    stall_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|stall_set_i) |=> ((stall_o & $past(stall_set_i)) == $past(stall_set_i)));

endmodule

// File: rtl/rr_picker.sv
`timescale 1ns/1ps
module rr_picker #(
    parameter int unsigned NUM_WARPS = 4,
    localparam int unsigned WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WARPS-1:0] req_i,
    output logic                 gnt_valid_o,
    output logic [WID_W-1:0]     gnt_id_o
);

    typedef struct packed {
        logic [WID_W-1:0] last;
    } rr_state_t;

    rr_state_t state_d, state_q;

    logic             found;
    logic [WID_W-1:0] pick;
    logic [WID_W:0]   cand;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        cand  = '0;
        for (int k = 1; k <= int'(NUM_WARPS); k++) begin
            cand = {1'b0, state_q.last} + (WID_W+1)'(k);
            if (cand >= (WID_W+1)'(NUM_WARPS)) begin
                cand = cand - (WID_W+1)'(NUM_WARPS);
            end
            if (!found && req_i[cand[WID_W-1:0]]) begin
                found = 1'b1;
                pick  = cand[WID_W-1:0];
            end
        end
        state_d = state_q;
        if (found) state_d.last = pick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q.last <= WID_W'(NUM_WARPS - 1);
        else        state_q      <= state_d;
    end

    assign gnt_valid_o = found;
    assign gnt_id_o    = pick;

    // R2
    rr_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o |-> req_i[gnt_id_o]);

    // R3
    rr_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid_o && $past(gnt_valid_o) && ($countones(req_i) > 1))
        |-> (gnt_id_o != $past(gnt_id_o)));

endmodule

// File: rtl/warp_ctx.sv
`timescale 1ns/1ps
module warp_ctx
    import warp_sched_pkg::*;
#(
    parameter int unsigned PC_W        = 16,
    parameter int unsigned STACK_DEPTH = 4,
    parameter logic [PC_W-1:0] RESET_PC = '0,
    localparam int unsigned SP_W       = $clog2(STACK_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_i,
    input  logic            br_valid_i,
    input  lane_mask_t      br_taken_i,
    input  logic [PC_W-1:0] br_target_i,
    input  logic [PC_W-1:0] br_reconv_i,
    output logic [PC_W-1:0] pc_o,
    output lane_mask_t      mask_o
);

    typedef struct packed {
        logic [PC_W-1:0] reconv;
        logic [PC_W-1:0] alt_pc;
        lane_mask_t      alt_mask;
        lane_mask_t      outer_mask;
    } frame_t;

    typedef struct packed {
        logic [PC_W-1:0]              pc;
        lane_mask_t                   mask;
        logic [SP_W-1:0]              sp;
        frame_t [STACK_DEPTH-1:0]     stk;
    } ctx_t;

    ctx_t            ctx_d, ctx_q;
    br_kind_e        br_kind;
    logic [SP_W-1:0] top_idx;

    always_comb begin
        ctx_d   = ctx_q;
        br_kind = classify_branch(br_valid_i, br_taken_i, ctx_q.mask);
        top_idx = '0;
        if (issue_i) begin
            unique case (br_kind)
                BK_ALL: ctx_d.pc = br_target_i;
                BK_SPLIT: begin
                    if (ctx_q.sp < SP_W'(STACK_DEPTH)) begin
                        ctx_d.stk[ctx_q.sp] = '{
                            reconv:     br_reconv_i,
                            alt_pc:     ctx_q.pc + PC_W'(1),
                            alt_mask:   ctx_q.mask & ~br_taken_i,
                            outer_mask: ctx_q.mask
                        };
                        ctx_d.sp   = ctx_q.sp + SP_W'(1);
                        ctx_d.pc   = br_target_i;
                        ctx_d.mask = ctx_q.mask & br_taken_i;
                    end else begin
                        ctx_d.pc = ctx_q.pc + PC_W'(1);
                    end
                end
                default: ctx_d.pc = ctx_q.pc + PC_W'(1);
            endcase
            if (ctx_d.sp != '0) begin
                top_idx = ctx_d.sp - SP_W'(1);
                if (ctx_d.pc == ctx_d.stk[top_idx].reconv) begin
                    if (ctx_d.stk[top_idx].alt_mask != '0) begin
                        ctx_d.pc                   = ctx_d.stk[top_idx].alt_pc;
                        ctx_d.mask                 = ctx_d.stk[top_idx].alt_mask;
                        ctx_d.stk[top_idx].alt_mask = '0;
                    end else begin
                        ctx_d.mask = ctx_d.stk[top_idx].outer_mask;
                        ctx_d.sp   = top_idx;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q      <= '0;
            ctx_q.pc   <= RESET_PC;
            ctx_q.mask <= '1;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign pc_o   = ctx_q.pc;
    assign mask_o = ctx_q.mask;

    // R9
    mask_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_o != '0);

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && br_kind == BK_SPLIT) |-> (ctx_q.sp < SP_W'(STACK_DEPTH)));

    // R9
    split_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && br_kind == BK_SPLIT && br_target_i != br_reconv_i)
        |=> (mask_o == $past(br_taken_i & mask_o)) && (pc_o == $past(br_target_i)));

    // R8
    uniform_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && (br_kind == BK_ALL || br_kind == BK_NONE) && ctx_q.sp == '0)
        |=> $stable(mask_o));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> ($stable(pc_o) && $stable(mask_o)));

endmodule

// File: rtl/warp_sched_top.sv
`timescale 1ns/1ps
module warp_sched_top
    import warp_sched_pkg::*;
#(
    parameter int unsigned NUM_WARPS   = 4,
    parameter int unsigned PC_W        = 16,
    parameter int unsigned STACK_DEPTH = 4,
    parameter int unsigned PC_STRIDE   = 256,
    localparam int unsigned WID_W      = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WARPS-1:0] warp_ready_i,
    input  logic [NUM_WARPS-1:0] stall_set_i,
    input  logic                 cpl_valid_i,
    input  logic [WID_W-1:0]     cpl_warp_i,
    input  logic                 br_valid_i,
    input  logic [LANES-1:0]     br_taken_i,
    input  logic [PC_W-1:0]      br_target_i,
    input  logic [PC_W-1:0]      br_reconv_i,
    output logic                 issue_valid_o,
    output logic                 idle_o,
    output logic [WID_W-1:0]     issue_warp_o,
    output logic [PC_W-1:0]      issue_pc_o,
    output logic [LANES-1:0]     issue_mask_o
);

    logic [NUM_WARPS-1:0] stall_vec;
    logic [NUM_WARPS-1:0] eligible;
    logic                 gnt_valid;
    logic [WID_W-1:0]     gnt_id;
    logic [PC_W-1:0]      warp_pc   [NUM_WARPS];
    lane_mask_t           warp_mask [NUM_WARPS];

    stall_tracker #(.NUM_WARPS(NUM_WARPS)) u_stall (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall_set_i (stall_set_i),
        .cpl_valid_i (cpl_valid_i),
        .cpl_warp_i  (cpl_warp_i),
        .stall_o     (stall_vec)
    );

    assign eligible = warp_ready_i & ~stall_vec;

    rr_picker #(.NUM_WARPS(NUM_WARPS)) u_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (eligible),
        .gnt_valid_o (gnt_valid),
        .gnt_id_o    (gnt_id)
    );

    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
        warp_ctx #(
            .PC_W        (PC_W),
            .STACK_DEPTH (STACK_DEPTH),
            .RESET_PC    (PC_W'(g * PC_STRIDE))
        ) u_ctx (
            .clk         (clk),
            .rst_n       (rst_n),
            .issue_i     (gnt_valid && (gnt_id == WID_W'(g))),
            .br_valid_i  (br_valid_i),
            .br_taken_i  (br_taken_i),
            .br_target_i (br_target_i),
            .br_reconv_i (br_reconv_i),
            .pc_o        (warp_pc[g]),
            .mask_o      (warp_mask[g])
        );
    end

    always_comb begin
        issue_valid_o = gnt_valid;
        idle_o        = !gnt_valid;
        issue_warp_o  = gnt_id;
        issue_pc_o    = warp_pc[gnt_id];
        issue_mask_o  = warp_mask[gnt_id];
    end

    // R5
    stall_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o |-> (!stall_vec[issue_warp_o] && warp_ready_i[issue_warp_o]));

    // R4
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warp_ready_i == '0) |-> (idle_o && !issue_valid_o));

endmodule

// File: tb/tb_warp_sched_top.sv
`timescale 1ns/1ps
module tb_warp_sched_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  warp_ready_i = '0;
    logic [3:0]  stall_set_i = '0;
    logic        cpl_valid_i = 1'b0;
    logic [1:0]  cpl_warp_i = '0;
    logic        br_valid_i = 1'b0;
    logic [31:0] br_taken_i = '0;
    logic [15:0] br_target_i = '0;
    logic [15:0] br_reconv_i = '0;
    logic        issue_valid_o;
    logic        idle_o;
    logic [1:0]  issue_warp_o;
    logic [15:0] issue_pc_o;
    logic [31:0] issue_mask_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    localparam logic [31:0] FULL = 32'hFFFF_FFFF;

    typedef struct {
        bit          v;
        int          w;
        logic [15:0] pc;
        logic [31:0] mask;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    warp_sched_top dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .warp_ready_i  (warp_ready_i),
        .stall_set_i   (stall_set_i),
        .cpl_valid_i   (cpl_valid_i),
        .cpl_warp_i    (cpl_warp_i),
        .br_valid_i    (br_valid_i),
        .br_taken_i    (br_taken_i),
        .br_target_i   (br_target_i),
        .br_reconv_i   (br_reconv_i),
        .issue_valid_o (issue_valid_o),
        .idle_o        (idle_o),
        .issue_warp_o  (issue_warp_o),
        .issue_pc_o    (issue_pc_o),
        .issue_mask_o  (issue_mask_o)
    );

    task automatic drive(input logic [3:0] rdy, input logic [3:0] sset,
                         input bit cv, input int cw,
                         input bit bv, input logic [31:0] tk,
                         input logic [15:0] tgt, input logic [15:0] rcv,
                         input bit ev, input int ew, input logic [15:0] epc,
                         input logic [31:0] emask, input string tag);
        exp_t e;
        @(negedge clk);
        warp_ready_i = rdy;
        stall_set_i  = sset;
        cpl_valid_i  = cv;
        cpl_warp_i   = 2'(cw);
        br_valid_i   = bv;
        br_taken_i   = tk;
        br_target_i  = tgt;
        br_reconv_i  = rcv;
        e.v = ev; e.w = ew; e.pc = epc; e.mask = emask; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic plain(input logic [3:0] rdy, input bit ev, input int ew,
                         input logic [15:0] epc, input logic [31:0] emask,
                         input string tag);
        drive(rdy, 4'b0, 1'b0, 0, 1'b0, '0, '0, '0, ev, ew, epc, emask, tag);
    endtask

    task automatic branch(input logic [31:0] tk, input logic [15:0] tgt,
                          input logic [15:0] rcv, input logic [15:0] epc,
                          input logic [31:0] emask, input string tag);
        drive(4'b0001, 4'b0, 1'b0, 0, 1'b1, tk, tgt, rcv, 1'b1, 0, epc, emask, tag);
    endtask

    // Monitor: pops one expectation per cycle, away from the rising edge.
    always begin
        @(negedge clk);
        #2;
        if (sb.size() != 0) begin
            exp_t e;
            bit bad;
            e = sb.pop_front();
            checks++;
            bad = (issue_valid_o !== e.v) || (idle_o !== !e.v);
            if (e.v && !bad) begin
                bad = (int'(issue_warp_o) != e.w) || (issue_pc_o !== e.pc) ||
                      (issue_mask_o !== e.mask);
            end
            if (bad) begin
                failures++;
                $display("FAIL %s: got valid=%0b idle=%0b warp=%0d pc=%h mask=%h, expected valid=%0b warp=%0d pc=%h mask=%h",
                         e.tag, issue_valid_o, idle_o, issue_warp_o, issue_pc_o,
                         issue_mask_o, e.v, e.w, e.pc, e.mask);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R4: nothing ready after reset
        plain(4'b0000, 0, 0, 16'h000, FULL, "R4");
        // R1: warp 0 first, reset pc and full mask
        plain(4'b1111, 1, 0, 16'h000, FULL, "R1");
        // R3: rotation
        plain(4'b1111, 1, 1, 16'h100, FULL, "R3");
        // R5: stall request on warp 2 does not affect this cycle
        drive(4'b1111, 4'b0100, 1'b0, 0, 1'b0, '0, '0, '0, 1, 2, 16'h200, FULL, "R5");
        plain(4'b1111, 1, 3, 16'h300, FULL, "R3");
        plain(4'b1111, 1, 0, 16'h001, FULL, "R3");
        plain(4'b1111, 1, 1, 16'h101, FULL, "R2");
        // R5: warp 2 stalled is skipped; completion for warp 2 applied now
        drive(4'b1111, 4'b0000, 1'b1, 2, 1'b0, '0, '0, '0, 1, 3, 16'h301, FULL, "R5");
        // R6: warp 2 released
        plain(4'b0100, 1, 2, 16'h201, FULL, "R6");
        // R6: stall and completion on warp 0 together, stall wins
        drive(4'b0000, 4'b0001, 1'b1, 0, 1'b0, '0, '0, '0, 0, 0, 16'h0, FULL, "R4");
        plain(4'b0001, 0, 0, 16'h000, FULL, "R6");
        drive(4'b0000, 4'b0000, 1'b1, 0, 1'b0, '0, '0, '0, 0, 0, 16'h0, FULL, "R4");
        plain(4'b0001, 1, 0, 16'h002, FULL, "R6");
        // R3: rotation with gaps
        plain(4'b1010, 1, 1, 16'h102, FULL, "R3");
        plain(4'b1010, 1, 3, 16'h302, FULL, "R3");
        plain(4'b1010, 1, 1, 16'h103, FULL, "R3");
        // R8: uniform taken
        branch(FULL, 16'h010, 16'h020, 16'h003, FULL, "R8");
        // R8: uniform not taken, target ignored
        branch(32'h0, 16'h050, 16'h020, 16'h010, FULL, "R8");
        // R8 check of pc 011; divergent split at 011
        branch(32'h0000_FFFF, 16'h040, 16'h013, 16'h011, FULL, "R8");
        // R9: taken path first with taken lanes only
        plain(4'b0001, 1, 0, 16'h040, 32'h0000_FFFF, "R9");
        // R7: pc advanced by one; nested split
        branch(32'h0000_00FF, 16'h060, 16'h043, 16'h041, 32'h0000_FFFF, "R7");
        plain(4'b0001, 1, 0, 16'h060, 32'h0000_00FF, "R9");
        // R12: inactive lanes' taken bits ignored -> uniform jump to reconv
        branch(FULL, 16'h043, 16'h000, 16'h061, 32'h0000_00FF, "R12");
        // R10: held-back lanes of inner branch
        plain(4'b0001, 1, 0, 16'h042, 32'h0000_FF00, "R10");
        // R11: inner pop restores mask
        plain(4'b0001, 1, 0, 16'h043, 32'h0000_FFFF, "R11");
        // R12: jump to outer reconv with inactive taken bits set
        branch(FULL, 16'h013, 16'h000, 16'h044, 32'h0000_FFFF, "R12");
        // R10: outer held-back lanes
        plain(4'b0001, 1, 0, 16'h012, 32'hFFFF_0000, "R10");
        // R11: outer pop, full mask at reconv address
        plain(4'b0001, 1, 0, 16'h013, FULL, "R11");
        // R7: idle warp 1 kept its state
        plain(4'b0010, 1, 1, 16'h104, FULL, "R7");
        // R11: warp 0 continues after reconvergence
        plain(4'b0001, 1, 0, 16'h014, FULL, "R11");
        plain(4'b0000, 0, 0, 16'h000, FULL, "R4");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got no completion, expected end of sequence");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule